// File: doc/BRIEF.md
# Host Serial Command and Status Port

This block is the device side of a slow synchronous serial link between an external host and a media player controller. The host drives a clock line and a data line. Each frame opens with three synchronisation clocks, followed by an 8-bit command code that is shifted in most significant bit first. Recognised codes become single-cycle strobes for the player core. Unrecognised codes are dropped.

A status-read command starts a second transfer. The host gives three more synchronisation clocks, then 56 data clocks. The block answers on a dedicated output line with a snapshot of the player state:
- the transport flags,
- the current folder and file numbers,
- the elapsed time in packed BCD.

Host clock and data are oversampled in the internal system clock domain. A tick counter enforces three timing rules: it discards frames whose clock pulses stretch too long, it rejects frames that arrive too soon after the previous command or status transfer, and it delays each status bit after its clock edge. A standby input silences the status line completely.

Top module: `sercmd_port`

## Requirements
- R1: After reset, `cmd_stb` is all zero and `sts_out` is low.
- R2: A frame whose command code is recognised and not a status read raises exactly one bit of `cmd_stb`, for exactly one system clock cycle, once per frame.
- R3: Strobe mapping, with at most one bit high at a time:
  - 0x01 → bit 0 (play)
  - 0x02 → bit 1 (pause)
  - 0x03 → bit 2 (stop)
  - 0x04 → bit 3 (fast forward)
  - 0x05 → bit 4 (fast back)
  - 0x06 → bit 5 (folder up)
  - 0x08 → bit 6 (folder down)
  - 0x0A → bit 7 (skip ten up)
  - 0x0B → bit 8 (skip ten down)
  - 0x0C → bit 9 (volume up)
  - 0x0D → bit 10 (volume down)
- R4: Any code other than the eleven in R3 and 0x09 produces no strobe and starts no status transfer.
- R5: Frame timing on the host side:
  - A frame is 3 synchronisation clocks followed by 8 command bits.
  - Data is sampled on rising edges of `host_clk`, MSB first.
  - After code 0x09, 3 synchronisation clocks and then 56 data clocks follow.
  - Status bit 55 is driven after the first of the 56 data rising edges, and bit 0 after the last.
  - `sts_out` returns low after the falling edge that follows the 56th data clock.
- R6: Status word layout (S55 down to S0):
  - S55 play, S54 pause, S53 stop, S52 access, S51 error.
  - S50..S48 read as zero.
  - S47..S32 folder number, S31..S16 file number.
  - S15..S8 minutes (BCD), S7..S0 seconds (BCD).
- R7: The status word is frozen when the status-read command is decoded. Changes to the live inputs during the transfer do not alter the bits shifted out.
- R8: A status bit never changes `sts_out` in the system cycle right after the `host_clk` rising edge that requests it. It appears at least OUT_DLY_TICKS ticks after that edge is detected.
- R9: While `standby` is high, `sts_out` is low. A status-read command decoded while `standby` is high starts no transfer.
- R10: A `host_clk` level held for PULSE_MAX_TICKS ticks inside a frame discards the frame. The frame produces no strobe, and the next frame is received normally.
- R11: The first clock of a frame that arrives within CMD_GAP_TICKS ticks of the previous command decode causes that whole 11-clock frame to be ignored.
- R12: After a status transfer ends, only STS_GAP_TICKS ticks (shorter than the command gap) must pass before a new command is accepted. An earlier frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk | input | 1 | Host serial clock, asynchronous |
| host_data | input | 1 | Host serial data, asynchronous |
| standby | input | 1 | Forces the status line low and blocks status transfers |
| play_flag | input | 1 | Live playing flag |
| pause_flag | input | 1 | Live pausing flag |
| stop_flag | input | 1 | Live stopped flag |
| access_flag | input | 1 | Live media-access flag |
| error_flag | input | 1 | Live error flag |
| folder_num | input | 16 | Current folder number, binary |
| file_num | input | 16 | Current file number, binary |
| time_min_bcd | input | 8 | Elapsed minutes, two BCD digits |
| time_sec_bcd | input | 8 | Elapsed seconds, two BCD digits |
| cmd_stb | output | 11 | One-cycle command strobes, mapping per R3 |
| sts_out | output | 1 | Serial status output line |

## Verification
The functions that can coincide are the decode of a status-read command and the standby input. When the final command bit is sampled, the decoder may be asked to start a status transfer in the very cycle standby forbids it. The bench raises standby before the last command clock of a 0x09 frame, so standby is high in the decode cycle. It then clocks the full 59-clock transfer and requires `sts_out` to stay low throughout. A later normal read must still return the correct word.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int STB_W     = 11;
    localparam int STS_W     = 56;
    localparam int SYNC_CLKS = 3;
    localparam int CMD_BITS  = 8;
    localparam int CNT_W     = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSYNC,
        ST_CDATA,
        ST_SKIP,
        ST_SSYNC,
        ST_SDATA,
        ST_STAIL
    } frame_state_e;

    typedef struct packed {
        logic        play;
        logic        pause;
        logic        stop;
        logic        access;
        logic        error;
        logic [2:0]  rsv;
        logic [15:0] folder;
        logic [15:0] file;
        logic [7:0]  minutes;
        logic [7:0]  seconds;
    } status_word_t;

    typedef struct packed {
        logic       known;
        logic       rd;
        logic [3:0] idx;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] code);
        cmd_dec_t d;
        d       = '0;
        d.known = 1'b1;
        case (code)
            8'h01:   d.idx = 4'd0;
            8'h02:   d.idx = 4'd1;
            8'h03:   d.idx = 4'd2;
            8'h04:   d.idx = 4'd3;
            8'h05:   d.idx = 4'd4;
            8'h06:   d.idx = 4'd5;
            8'h08:   d.idx = 4'd6;
            8'h09:   d.rd  = 1'b1;
            8'h0A:   d.idx = 4'd7;
            8'h0B:   d.idx = 4'd8;
            8'h0C:   d.idx = 4'd9;
            8'h0D:   d.idx = 4'd10;
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [STB_W-1:0] strobe_of(input cmd_dec_t d);
        logic [STB_W-1:0] v;
        v = '0;
        if (d.known && !d.rd) v[d.idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], din[i]};
        end
        assign lvl[i]  = sh[1];
        assign rise[i] = sh[1] & ~sh[2];
        assign fall[i] = ~sh[1] & sh[2];
    end
endmodule

// File: rtl/sercmd_timer.sv
module sercmd_timer #(
    parameter int TICK_DIV  = 10,
    parameter int PULSE_MAX = 200,
    parameter int CMD_GAP   = 2200,
    parameter int STS_GAP   = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic host_edge,
    input  logic load_cmd_gap,
    input  logic load_sts_gap,
    output logic tick,
    output logic pulse_long,
    output logic gap_busy
);
    localparam int GAP_MAX = (CMD_GAP > STS_GAP) ? CMD_GAP : STS_GAP;
    localparam int GW      = $clog2(GAP_MAX + 1);
    localparam int PW      = $clog2(PULSE_MAX + 1);

    if (TICK_DIV <= 1) begin : g_fast
        assign tick = 1'b1;
    end else begin : g_div
        localparam int DW = $clog2(TICK_DIV);
        logic [DW-1:0] div_q;
        always_ff @(posedge clk) begin
            if (rst)                              div_q <= '0;
            else if (div_q == DW'(TICK_DIV - 1))  div_q <= '0;
            else                                  div_q <= div_q + 1'b1;
        end
        assign tick = (div_q == DW'(TICK_DIV - 1));
    end

    logic [PW-1:0] pw_q;
    always_ff @(posedge clk) begin
        if (rst || host_edge)                       pw_q <= '0;
        else if (tick && pw_q != PW'(PULSE_MAX))    pw_q <= pw_q + 1'b1;
    end
    assign pulse_long = (pw_q == PW'(PULSE_MAX));

    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                       gap_q <= '0;
        else if (load_sts_gap)         gap_q <= GW'(STS_GAP);
        else if (load_cmd_gap)         gap_q <= GW'(CMD_GAP);
        else if (tick && gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
    assign gap_busy = (gap_q != '0);
endmodule

// File: rtl/sercmd_status.sv
module sercmd_status
    import sercmd_pkg::*;
#(
    parameter int OUT_DLY = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         capture,
    input  status_word_t word_in,
    input  logic         bit_req,
    input  logic         clear,
    output logic         sts_o
);
    localparam int DLW = $clog2(OUT_DLY + 1);

    logic [STS_W-1:0] shadow_q;
    logic [DLW-1:0]   dly_q;
    logic             pend_q;
    logic             sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            dly_q    <= '0;
            pend_q   <= 1'b0;
            sts_q    <= 1'b0;
        end else if (clear) begin
            pend_q <= 1'b0;
            sts_q  <= 1'b0;
        end else begin
            if (capture) shadow_q <= word_in;
            if (bit_req) begin
                pend_q <= 1'b1;
                dly_q  <= DLW'(OUT_DLY);
            end else if (pend_q) begin
                if (dly_q == '0) begin
                    sts_q    <= shadow_q[STS_W-1];
                    shadow_q <= {shadow_q[STS_W-2:0], 1'b0};
                    pend_q   <= 1'b0;
                end else if (tick) begin
                    dly_q <= dly_q - 1'b1;
                end
            end
        end
    end
    assign sts_o = sts_q;
endmodule

// File: rtl/sercmd_frame.sv
module sercmd_frame
    import sercmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hc_rise,
    input  logic             hc_fall,
    input  logic             hd_lvl,
    input  logic             pulse_long,
    input  logic             gap_busy,
    input  logic             standby,
    output logic [STB_W-1:0] stb,
    output logic             capture,
    output logic             bit_req,
    output logic             clear,
    output logic             load_cmd_gap,
    output logic             load_sts_gap
);
    frame_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [6:0]       shreg_q;
    logic [STB_W-1:0] stb_q;

    logic [7:0] code_now;
    cmd_dec_t   dec;
    logic       in_frame;
    logic       timeout;
    logic       last_bit;
    logic       tail_end;

    assign code_now = {shreg_q, hd_lvl};
    assign dec      = decode_cmd(code_now);
    assign in_frame = (state_q != ST_IDLE);
    assign timeout  = in_frame && pulse_long;
    assign last_bit = (state_q == ST_CDATA) && hc_rise && !timeout
                      && (cnt_q == CNT_W'(CMD_BITS - 1));
    assign tail_end = (state_q == ST_STAIL) && hc_fall && !timeout;

    assign capture      = last_bit && dec.rd && !standby;
    assign bit_req      = (state_q == ST_SDATA) && hc_rise && !timeout && !standby;
    assign clear        = timeout || standby || tail_end;
    assign load_cmd_gap = last_bit;
    assign load_sts_gap = tail_end;
    assign stb          = stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            stb_q   <= '0;
        end else begin
            stb_q <= '0;
            if (timeout) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: if (hc_rise) begin
                        state_q <= gap_busy ? ST_SKIP : ST_CSYNC;
                        cnt_q   <= CNT_W'(1);
                    end
                    ST_CSYNC: if (hc_rise) begin
                        if (cnt_q == CNT_W'(SYNC_CLKS - 1)) begin
                            state_q <= ST_CDATA;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_CDATA: if (hc_rise) begin
                        shreg_q <= code_now[6:0];
                        if (last_bit) begin
                            stb_q   <= strobe_of(dec);
                            state_q <= (dec.rd && !standby) ? ST_SSYNC : ST_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_SKIP: if (hc_rise) begin
                        if (cnt_q == CNT_W'(SYNC_CLKS + CMD_BITS - 1)) state_q <= ST_IDLE;
                        else                                           cnt_q   <= cnt_q + 1'b1;
                    end
                    ST_SSYNC: begin
                        if (standby) begin
                            state_q <= ST_IDLE;
                        end else if (hc_rise) begin
                            if (cnt_q == CNT_W'(SYNC_CLKS - 1)) begin
                                state_q <= ST_SDATA;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_SDATA: begin
                        if (standby) begin
                            state_q <= ST_IDLE;
                        end else if (hc_rise) begin
                            if (cnt_q == CNT_W'(STS_W - 1)) state_q <= ST_STAIL;
                            else                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    ST_STAIL: begin
                        if (standby || hc_fall) state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sercmd_port.sv
module sercmd_port
    import sercmd_pkg::*;
#(
    parameter int TICK_DIV        = 10,
    parameter int PULSE_MAX_TICKS = 200,
    parameter int CMD_GAP_TICKS   = 2200,
    parameter int STS_GAP_TICKS   = 500,
    parameter int OUT_DLY_TICKS   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clk,
    input  logic             host_data,
    input  logic             standby,
    input  logic             play_flag,
    input  logic             pause_flag,
    input  logic             stop_flag,
    input  logic             access_flag,
    input  logic             error_flag,
    input  logic [15:0]      folder_num,
    input  logic [15:0]      file_num,
    input  logic [7:0]       time_min_bcd,
    input  logic [7:0]       time_sec_bcd,
    output logic [STB_W-1:0] cmd_stb,
    output logic             sts_out
);
    logic [1:0] s_lvl, s_rise, s_fall;
    logic tick, pulse_long, gap_busy;
    logic capture, bit_req, clear, load_cmd_gap, load_sts_gap;
    status_word_t live_word;

    sercmd_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({host_data, host_clk}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    sercmd_timer #(
        .TICK_DIV  (TICK_DIV),
        .PULSE_MAX (PULSE_MAX_TICKS),
        .CMD_GAP   (CMD_GAP_TICKS),
        .STS_GAP   (STS_GAP_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .host_edge    (s_rise[0] | s_fall[0]),
        .load_cmd_gap (load_cmd_gap),
        .load_sts_gap (load_sts_gap),
        .tick         (tick),
        .pulse_long   (pulse_long),
        .gap_busy     (gap_busy)
    );

    sercmd_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .hc_rise      (s_rise[0]),
        .hc_fall      (s_fall[0]),
        .hd_lvl       (s_lvl[1]),
        .pulse_long   (pulse_long),
        .gap_busy     (gap_busy),
        .standby      (standby),
        .stb          (cmd_stb),
        .capture      (capture),
        .bit_req      (bit_req),
        .clear        (clear),
        .load_cmd_gap (load_cmd_gap),
        .load_sts_gap (load_sts_gap)
    );

    always_comb begin
        live_word         = '0;
        live_word.play    = play_flag;
        live_word.pause   = pause_flag;
        live_word.stop    = stop_flag;
        live_word.access  = access_flag;
        live_word.error   = error_flag;
        live_word.folder  = folder_num;
        live_word.file    = file_num;
        live_word.minutes = time_min_bcd;
        live_word.seconds = time_sec_bcd;
    end

    sercmd_status #(.OUT_DLY(OUT_DLY_TICKS)) u_status (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .capture (capture),
        .word_in (live_word),
        .bit_req (bit_req),
        .clear   (clear),
        .sts_o   (sts_out)
    );
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk
    import sercmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_clk,
    input logic             standby,
    input logic [STB_W-1:0] cmd_stb,
    input logic             sts_out
);
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb)); // R3

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb != '0) |=> (cmd_stb == '0)); // R2

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        standby |=> !sts_out); // R9

    AST_NO_EARLY_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(host_clk) |=> !$rose(sts_out)); // R8
endmodule

bind sercmd_port sercmd_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_clk (host_clk),
    .standby  (standby),
    .cmd_stb  (cmd_stb),
    .sts_out  (sts_out)
);

// File: tb/sim_sercmd_port.sv
module sim_sercmd_port;
    import sercmd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int IDLE_GAP   = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_clk = 1'b0, host_data = 1'b0, standby = 1'b0;
    logic play_flag = 0, pause_flag = 0, stop_flag = 0, access_flag = 0, error_flag = 0;
    logic [15:0] folder_num = '0, file_num = '0;
    logic [7:0]  time_min_bcd = '0, time_sec_bcd = '0;
    logic [STB_W-1:0] cmd_stb;
    logic sts_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercmd_port #(
        .TICK_DIV(1), .PULSE_MAX_TICKS(40), .CMD_GAP_TICKS(60),
        .STS_GAP_TICKS(30), .OUT_DLY_TICKS(3)
    ) u0 (.*);

    int   stb_cnt [STB_W];
    logic mon_clr = 1'b0;
    always @(posedge clk) begin
        for (int i = 0; i < STB_W; i++) begin
            if (mon_clr)         stb_cnt[i] <= 0;
            else if (cmd_stb[i]) stb_cnt[i] <= stb_cnt[i] + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    task automatic pulse(input logic d);
        host_data = d;
        idle(HALF);
        host_clk = 1'b1;
        idle(HALF);
        host_clk = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        repeat (3) pulse(1'b0);
        for (int i = 7; i >= 0; i--) pulse(c[i]);
    endtask

    function automatic logic [STB_W-1:0] exp_mask(input logic [7:0] c);
        case (c)
            8'h01: return 11'd1 << 0;
            8'h02: return 11'd1 << 1;
            8'h03: return 11'd1 << 2;
            8'h04: return 11'd1 << 3;
            8'h05: return 11'd1 << 4;
            8'h06: return 11'd1 << 5;
            8'h08: return 11'd1 << 6;
            8'h0A: return 11'd1 << 7;
            8'h0B: return 11'd1 << 8;
            8'h0C: return 11'd1 << 9;
            8'h0D: return 11'd1 << 10;
            default: return '0;
        endcase
    endfunction

    task automatic check_strobes(input logic [STB_W-1:0] exp, input string req, input string what);
        logic [STB_W-1:0] got;
        int total;
        got = '0;
        total = 0;
        for (int i = 0; i < STB_W; i++) begin
            if (stb_cnt[i] != 0) got[i] = 1'b1;
            total += stb_cnt[i];
        end
        check(got == exp && total == $countones(exp), req,
              $sformatf("%s strobe mask (total %0d)", what, total), got, exp);
    endtask

    function automatic logic [55:0] exp_word();
        return {play_flag, pause_flag, stop_flag, access_flag, error_flag, 3'b000,
                folder_num, file_num, time_min_bcd, time_sec_bcd};
    endfunction

    task automatic set_inputs(input logic [55:0] w);
        {play_flag, pause_flag, stop_flag, access_flag, error_flag} = w[55:51];
        folder_num   = w[47:32];
        file_num     = w[31:16];
        time_min_bcd = w[15:8];
        time_sec_bcd = w[7:0];
    endtask

    // Issues status read and clocks the 56-bit answer; optionally changes live inputs mid-way.
    task automatic read_status(input int chg_at, input logic [55:0] chg_val,
                               output logic [55:0] got, output int early_bad, output bit end_low);
        logic prev;
        send_cmd(8'h09);
        repeat (3) pulse(1'b0);
        prev = 1'b0;
        early_bad = 0;
        got = '0;
        for (int i = 55; i >= 0; i--) begin
            if (i == chg_at) set_inputs(chg_val);
            host_data = 1'b0;
            idle(HALF);
            host_clk = 1'b1;
            idle(1);
            if (sts_out !== prev) early_bad++;
            idle(HALF - 2);
            got[i] = sts_out;
            idle(1);
            host_clk = 1'b0;
            prev = got[i];
        end
        idle(8);
        end_low = (sts_out == 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [55:0] got, exp, pat;
        int  early;
        bit  endl;

        idle(5);
        rst = 1'b0;
        idle(2);
        check(cmd_stb == '0, "R1", "strobes after reset", cmd_stb, 0);
        check(sts_out == 1'b0, "R1", "status line after reset", sts_out, 0);

        // R2 R3 R4 R5: exhaustive sweep of command codes
        for (int c = 0; c < 256; c++) begin
            if (c == 9) continue;
            clr_mon();
            send_cmd(8'(c));
            idle(IDLE_GAP);
            check_strobes(exp_mask(8'(c)), exp_mask(8'(c)) != 0 ? "R3" : "R4",
                          $sformatf("code %02h", c));
        end

        // R6 R5 R8: several status patterns
        for (int p = 0; p < 4; p++) begin
            pat = {5'(5'h15 ^ (p * 7)), 3'b111, 16'(16'h0001 << (p * 4)),
                   16'(16'hFFFF >> p), 8'(8'h59 - p), 8'(8'h07 + p * 16)};
            set_inputs(pat);
            exp = exp_word();
            clr_mon();
            read_status(-1, '0, got, early, endl);
            check(got == exp, "R6", $sformatf("status word pattern %0d", p), got, exp);
            check(early == 0, "R8", "bit changed right after edge", early, 0);
            check(endl, "R5", "status line low after transfer", !endl, 0);
            check_strobes('0, "R4", "status read");
            idle(IDLE_GAP);
        end

        // R7: live inputs change in the middle of a transfer
        set_inputs(56'hA8_1234_5678_4523 | 56'h0);
        exp = exp_word();
        read_status(20, ~exp, got, early, endl);
        check(got == exp, "R7", "frozen snapshot", got, exp);
        idle(IDLE_GAP);

        // R11: command too soon after previous command
        clr_mon();
        send_cmd(8'h01);
        idle(10);
        send_cmd(8'h03);
        idle(IDLE_GAP);
        check_strobes(11'b001, "R11", "early second command");
        clr_mon();
        send_cmd(8'h03);
        idle(IDLE_GAP);
        check_strobes(11'b100, "R11", "command after gap");

        // R12: status gap shorter than command gap
        set_inputs(56'h0);
        read_status(-1, '0, got, early, endl);
        clr_mon();
        idle(5);
        send_cmd(8'h02);
        idle(IDLE_GAP);
        check_strobes('0, "R12", "command right after status");
        read_status(-1, '0, got, early, endl);
        clr_mon();
        idle(40);
        send_cmd(8'h02);
        idle(IDLE_GAP);
        check_strobes(11'b010, "R12", "command after status gap");

        // R10: stretched high and low pulses inside a frame
        clr_mon();
        repeat (3) pulse(1'b0);
        repeat (4) pulse(1'b0);
        host_clk = 1'b1;
        idle(80);
        host_clk = 1'b0;
        idle(IDLE_GAP);
        send_cmd(8'h02);
        idle(IDLE_GAP);
        check_strobes(11'b010, "R10", "after long high pulse");
        clr_mon();
        repeat (3) pulse(1'b0);
        pulse(1'b1);
        pulse(1'b1);
        idle(80);
        send_cmd(8'h05);
        idle(IDLE_GAP);
        check_strobes(11'b1_0000, "R10", "after long low phase");

        // R9: standby high during status-read decode and transfer
        set_inputs({56{1'b1}});
        standby = 1'b1;
        early = 0;
        repeat (3) pulse(1'b0);
        for (int i = 7; i >= 0; i--) pulse(i == 0 || i == 3);
        for (int i = 0; i < 59; i++) begin
            host_data = 1'b0;
            idle(HALF);
            host_clk = 1'b1;
            idle(HALF - 1);
            if (sts_out) early++;
            idle(1);
            host_clk = 1'b0;
        end
        check(early == 0, "R9", "status high cycles in standby", early, 0);
        idle(IDLE_GAP);
        standby = 1'b0;
        idle(IDLE_GAP);
        exp = exp_word();
        read_status(-1, '0, got, early, endl);
        check(got == exp, "R9", "read after standby released", got, exp);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule